// File: doc/BRIEF.md
# Quad Recirculating Serial Shift Register

This block holds four independent serial shift registers of 80 bits each. All four move together, one place toward their output end, each time a shared shift strobe goes from high to low. Each channel has its own serial data input, its own serial output and its own recirculate select. With the select low, the channel takes new data from its input. With the select high, the bit leaving the output end is written back into the input end. A channel in that state is a circulating delay-line memory that keeps its contents indefinitely.

The shift strobe is treated as data. It is sampled on the fast system clock, and a high sample followed by a low sample counts as one shift event. The shift is applied on the system-clock edge that sees the low sample. Each channel stores its bits as a chain of fixed-width words. Word 0 holds the output end, and new bits enter at the top bit of the last word.

Top module: `quad_recirc_shreg`

## Requirements
- R1: Each channel is 80 bits long. A bit taken in on a shift event appears on that channel's `ser_out` after the 79th later shift event (the 80th counting its own). Bits that have not yet reached the output end never appear early.
- R2: A shift happens only when one system-clock sample of `shift_clk` is 1 and the next sample is 0. Rising transitions and steady levels (high or low) leave every `ser_out` unchanged.
- R3: On a shift event where a channel's `recirc` bit is 1, the bit entering that channel is the `ser_out` value it had before the shift, and that channel's `ser_in` has no effect.
- R4: On a shift event where a channel's `recirc` bit is 0, the bit entering that channel is that channel's `ser_in` bit.
- R5: After 80 shift events in a row with `recirc` at 1, a channel holds exactly the contents it held before them, so the following 80 outputs repeat the previous 80.
- R6: While `rst_n` is sampled low on a system-clock edge, all storage and the stored previous `shift_clk` sample are cleared to 0. The first edge after release therefore never shifts, even if `shift_clk` was high during reset.
- R7: `ser_out` shows the shifted value right after the system-clock edge that samples `shift_clk` low following a high sample. There is no extra cycle of latency.
- R8: Channel c uses only bit c of `ser_in` and `recirc`. Channels in different modes during the same shift events do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the shift strobe |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Shared shift strobe; a high-to-low change shifts all channels |
| ser_in | input | NUM_CH (4) | Serial data input, bit c for channel c |
| recirc | input | NUM_CH (4) | Recirculate select, bit c for channel c (1 = feed back output) |
| ser_out | output | NUM_CH (4) | Output-end bit of each channel, bit c for channel c |

## Verification
A single shift event both loads a new bit into the input end and reads the output-end bit, and with recirculation on those two are the same bit. The entering value must therefore be the output from before the shift. The bench provokes this in two ways. It circulates a known 80-bit pattern for two full revolutions while driving the inverse pattern on `ser_in`, and it checks every output against the pattern at the expected offset. A second run puts half the channels in recirculation and the other half in loading during the same events, and it checks that after one full length the loading channels show the new data while the circulating channels still show the old pattern.

// File: rtl/qrs_pkg.sv
// Package: shared geometry of the quad recirculating shift register.
// Assumes every channel is built from NUM_WORDS words of WORD_W bits.
package qrs_pkg;
    localparam int NUM_CH_DEF    = 4;
    localparam int WORD_W_DEF    = 16;
    localparam int NUM_WORDS_DEF = 5;
    localparam int CHAIN_LEN_DEF = WORD_W_DEF * NUM_WORDS_DEF;
endpackage

// File: rtl/qrs_fall_detect.sv
// Module: qrs_fall_detect
// Samples the shift strobe on the system clock and flags a high-to-low
// change. Assumes the strobe is slow with respect to clk.
module qrs_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    output logic shift_en
);
    logic prev_q;

    // Keep the previous strobe sample; reset clears it so no fall follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= shift_clk;
    end

    // A fall is previous sample high and current sample low.
    always_comb shift_en = prev_q & ~shift_clk;
endmodule

// File: rtl/qrs_word.sv
// Module: qrs_word
// One storage word of a chain. On shift_en it moves right by one bit and
// takes top_in into its most significant bit. Assumes a synchronous reset.
module qrs_word #(
    parameter int WORD_W = qrs_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              top_in,
    output logic [WORD_W-1:0] word_q
);
    // Shift toward bit 0 on each shift event.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {top_in, word_q[WORD_W-1:1]};
    end
endmodule

// File: rtl/qrs_channel.sv
// Module: qrs_channel
// One serial channel built from NUM_WORDS words. Word 0 holds the output
// end; the entering bit goes into the top of the last word. The entering
// bit is the channel input or, with recirc set, the current output bit.
module qrs_channel #(
    parameter int WORD_W    = qrs_pkg::WORD_W_DEF,
    parameter int NUM_WORDS = qrs_pkg::NUM_WORDS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic ser_in,
    input  logic recirc,
    output logic ser_out
);
    logic [WORD_W-1:0]    word_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] link;
    logic                 entry_bit;

    // Pick the bit that enters the chain: feedback or external data.
    always_comb entry_bit = recirc ? ser_out : ser_in;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (w == NUM_WORDS - 1) begin : g_last
            assign link[w] = entry_bit;
        end else begin : g_mid
            assign link[w] = word_q[w+1][0];
        end
        qrs_word #(.WORD_W(WORD_W)) word_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .top_in   (link[w]),
            .word_q   (word_q[w])
        );
    end

    // Output end is bit 0 of word 0, the oldest stored bit.
    always_comb ser_out = word_q[0][0];
endmodule

// File: rtl/quad_recirc_shreg.sv
// Module: quad_recirc_shreg
// NUM_CH serial shift channels sharing one shift strobe. Each channel has
// its own data input, recirculate select and output. Assumes the strobe
// is asynchronous data that is slow compared with clk.
module quad_recirc_shreg #(
    parameter int NUM_CH    = qrs_pkg::NUM_CH_DEF,
    parameter int WORD_W    = qrs_pkg::WORD_W_DEF,
    parameter int NUM_WORDS = qrs_pkg::NUM_WORDS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic [NUM_CH-1:0] ser_in,
    input  logic [NUM_CH-1:0] recirc,
    output logic [NUM_CH-1:0] ser_out
);
    logic shift_en;

    qrs_fall_detect fall_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_clk (shift_clk),
        .shift_en  (shift_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qrs_channel #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .ser_in   (ser_in[c]),
            .recirc   (recirc[c]),
            .ser_out  (ser_out[c])
        );
    end
endmodule

// File: rtl/qrs_checker.sv
// Module: qrs_checker
// Port-level properties of quad_recirc_shreg, attached by bind.
module qrs_checker #(
    parameter int NUM_CH = qrs_pkg::NUM_CH_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_clk,
    input logic [NUM_CH-1:0] ser_out
);
    logic started = 1'b0;
    logic rst_d   = 1'b0;

    // Track reset history for the immediate reset check.
    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_d   <= rst_n;
        if (started && !rst_d) begin
            assert_reset_clears_R6: assert (ser_out == '0)
                else $error("reset did not clear outputs");
        end
    end

    // No fall seen: outputs keep their value.
    assert_hold_without_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(rst_n) && $past(shift_clk) && !shift_clk) |=> $stable(ser_out));

    // A rising strobe never shifts.
    assert_rise_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(shift_clk) && shift_clk) |=> $stable(ser_out));

    // The first edge after release never shifts.
    assert_first_edge_no_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (ser_out == '0));
endmodule

bind quad_recirc_shreg qrs_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_clk (shift_clk),
    .ser_out   (ser_out)
);

// File: tb/quad_recirc_shreg_tb_top.sv
module quad_recirc_shreg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_clk = 1'b0;
    logic [3:0] ser_in = '0;
    logic [3:0] recirc = '0;
    logic [3:0] ser_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_recirc_shreg dut_i (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk),
        .ser_in(ser_in), .recirc(recirc), .ser_out(ser_out)
    );

    function automatic logic pat(int c, int i);
        return ((i*5 + c*11 + i/3) % 7) < 3;
    endfunction

    function automatic logic [3:0] patv(int i);
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = pat(c, i);
        return v;
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: ser_out=%b expected=%b", req, act, exp);
        end
    endtask

    // One strobe pulse: high for a cycle, then low; returns after the shift.
    task automatic pulse(logic [3:0] rc, logic [3:0] din);
        @(negedge clk);
        shift_clk = 1'b1; recirc = rc; ser_in = din;
        @(negedge clk);
        shift_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R6 reset", ser_out, 4'h0);
    endtask

    // Load the pattern with recirc low; it surfaces after 80 events.
    task automatic t_load();
        for (int i = 0; i < LEN; i++) begin
            pulse(4'h0, patv(i));
            if (i < LEN - 1) chk("R1 early", ser_out, 4'h0);
            else             chk("R4 load", ser_out, patv(0));
        end
    endtask

    // Two full revolutions with recirc high and inverted data on ser_in.
    task automatic t_recirc();
        for (int j = 1; j <= LEN; j++) begin
            pulse(4'hF, ~patv(j % LEN));
            chk("R3 recirc", ser_out, patv(j % LEN));
        end
        for (int j = 1; j <= LEN; j++) begin
            pulse(4'hF, patv(j % LEN) ^ 4'h5);
            chk("R5 second pass", ser_out, patv(j % LEN));
        end
    endtask

    // Rising edge and steady levels do nothing; a fall shows at once.
    task automatic t_edges();
        @(negedge clk);
        shift_clk = 1'b1; recirc = 4'hF; ser_in = 4'h0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 high level", ser_out, patv(0));
        end
        shift_clk = 1'b0;
        @(posedge clk);
        #1;
        chk("R7 same cycle", ser_out, patv(1));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 low level", ser_out, patv(1));
        end
    endtask

    // Even channels circulate, odd channels load ones, in the same events.
    task automatic t_mixed();
        logic [3:0] exp;
        for (int j = 1; j <= 100; j++) begin
            pulse(4'b0101, 4'b1010);
            for (int c = 0; c < 4; c++)
                exp[c] = (c % 2 == 1 && j >= LEN) ? 1'b1 : pat(c, (1 + j) % LEN);
            chk("R8 mixed", ser_out, exp);
        end
    endtask

    // Reset with strobe high, release low: no spurious shift.
    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0; shift_clk = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; shift_clk = 1'b0; ser_in = 4'hF; recirc = 4'h0;
        repeat (3) @(negedge clk);
        chk("R6 cleared", ser_out, 4'h0);
        for (int j = 1; j <= LEN; j++) begin
            pulse(4'h0, 4'h0);
            chk("R6 no spurious shift", ser_out, 4'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_load();
        t_recirc();
        t_edges();
        t_mixed();
        t_reset_mid();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: ser_out=%b expected=finish", ser_out);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule